// File: doc/BRIEF.md
# Dual Comparator Output Conditioner

This block takes the two raw digital decisions of a pair of analog comparators and shapes them for three consumers: a pin driver, the analog output multiplexer, and the main path that feeds a sensing engine and interrupt logic. Each of the two channels computes a programmable Boolean function of both comparator bits. Call comparator 0 A and comparator 1 B. The result sets a per-channel sticky latch. Each consumer then takes either the live function result or the latched value.

The latch of a channel is cleared in one of two ways. The first is any register write. The second is a rising edge of the other channel's function output. This lets one comparator arm an event and the other comparator end it. Three byte-wide registers configure the block: channel enables, per-channel output control, and function codes. They are written and read through a plain address/data port. The comparators themselves are modelled as two synchronous input bits.

Top module: `dcc_top`

## Requirements
- R1: After reset all three registers read 0x00 and every output (main_out, pin_out, aout_en) is 0.
- R2: A write with wr_en high stores wr_data at offset 0 (enables), 1 (output control) or 2 (function codes). rd_data returns the stored byte of the offset on rd_addr. A write to offset 3 changes no register, and offset 3 reads 0x00.
- R3: Each channel's function output equals bit index {~A,~B} of its 4-bit code. Read MSB first, the code lists the outputs for (A,B) = 00, 01, 10, 11. Channel 0's code is in bits 3:0 of offset 2 and channel 1's code is in bits 7:4. Examples: 0 is constant 0, 15 is constant 1, 3 is A, 5 is B, 6 is XOR, 7 is OR, 8 is NOR, 9 is XNOR, 14 is NAND and 1 is AND.
- R4: Offset 0 bit 0 enables comparator 0 and bit 4 enables comparator 1. A disabled comparator's bit is taken as 0 by both channels.
- R5: Each channel's control nibble sits in offset 1, bits 3:0 for channel 0 and bits 7:4 for channel 1. Within the nibble, bit 0 of the nibble selects main_out: 0 gives the function output and 1 gives the latched value. The output changes on the clock edge after the input change.
- R6: Nibble bit 2 selects pin_out in the same way: 0 gives the function output and 1 gives the latched value.
- R7: Nibble bit 3 drives aout_en for that channel. It follows the register from the clock edge that writes it.
- R8: A channel's latch is set on every clock in which its function output is 1. Otherwise it holds its value until a clear event occurs.
- R9: With nibble bit 1 at 0, any write to offsets 0 to 2 clears the latch.
- R10: With nibble bit 1 at 1, register writes do not clear the latch. Instead, the latch clears on a clock in which the other channel's function output is 1 after being 0 on the previous clock. A level that stays high does not clear it.
- R11: When a set and a clear happen in the same clock, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read offset |
| rd_data | output | 8 | Stored value at rd_addr |
| cmp_raw | input | 2 | Raw comparator bits, bit 0 = A, bit 1 = B |
| main_out | output | 2 | Per-channel main path output (sensing/interrupt) |
| pin_out | output | 2 | Per-channel pin path output |
| aout_en | output | 2 | Per-channel analog output connect enable |

## Verification
A stuck or wrongly set latch does not show on main_out or pin_out while its select picks the function output. It appears on the first clock after a select bit is switched to the latched value, so the bench checks both selects with the latched value chosen. A mis-tracked edge history shows as a clear that comes one clock early or late, or as a clear repeated while the other channel's output stays high. The bench therefore checks a rising edge and a held level one clock apart. A wrong table index shows at once on the next clock, as an inverted or swapped function, across the twenty vectors.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int unsigned NCH   = 2;
  localparam int unsigned CODEW = 4;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 2;

  localparam logic [AW-1:0] OFS_EN  = 2'd0;
  localparam logic [AW-1:0] OFS_CTL = 2'd1;
  localparam logic [AW-1:0] OFS_FN  = 2'd2;

  // per-channel control nibble, MSB first
  typedef struct packed {
    logic aout;      // analog output connect
    logic pin_sel;   // pin path: 0 function, 1 latch
    logic rst_sel;   // clear source: 0 write, 1 opposite rising edge
    logic main_sel;  // main path: 0 function, 1 latch
  } chan_ctl_t;

  function automatic logic fn_eval(input logic [CODEW-1:0] code,
                                   input logic a, input logic b);
    logic [1:0] idx;
    idx = {~a, ~b};
    return code[idx];
  endfunction
endpackage

// File: rtl/dcc_rstsync.sv
module dcc_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dcc_regs.sv
module dcc_regs
  import dcc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [NCH-1:0] chan_en,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] fn_q,
  output logic          wr_hit
);
  logic [DW-1:0] en_q, en_d, ctl_d, fn_d;
  logic          en_ce, ctl_ce, fn_ce;

  always_comb begin
    en_ce  = wr_en && (wr_addr == OFS_EN);
    ctl_ce = wr_en && (wr_addr == OFS_CTL);
    fn_ce  = wr_en && (wr_addr == OFS_FN);
    wr_hit = en_ce || ctl_ce || fn_ce;
    en_d   = en_ce  ? wr_data : en_q;
    ctl_d  = ctl_ce ? wr_data : ctl_q;
    fn_d   = fn_ce  ? wr_data : fn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ctl_q <= '0;
      fn_q  <= '0;
    end else begin
      en_q  <= en_d;
      ctl_q <= ctl_d;
      fn_q  <= fn_d;
    end
  end

  // enable bits sit at the base of each channel's nibble
  for (genvar c = 0; c < NCH; c++) begin : g_en
    assign chan_en[c] = en_q[c*CODEW];
  end

  always_comb begin
    unique case (rd_addr)
      OFS_EN:  rd_data = en_q;
      OFS_CTL: rd_data = ctl_q;
      OFS_FN:  rd_data = fn_q;
      default: rd_data = '0;
    endcase
  end

  p_store_fn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_FN) |=> (fn_q == $past(wr_data)));

  p_bad_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr == 2'd3) |=> ($stable(en_q) && $stable(ctl_q) && $stable(fn_q)));
endmodule

// File: rtl/dcc_chan.sv
module dcc_chan
  import dcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_a,
  input  logic             in_b,
  input  logic [CODEW-1:0] code,
  input  chan_ctl_t        ctl,
  input  logic             wr_hit,
  input  logic             opp_fn,
  output logic             fn_out,
  output logic             main_q,
  output logic             pin_q,
  output logic             aout_en
);
  logic opp_prev_q, latch_q;
  logic latch_d, main_d, pin_d, opp_rise, clr;

  always_comb begin
    fn_out   = fn_eval(code, in_a, in_b);
    opp_rise = opp_fn && !opp_prev_q;
    clr      = ctl.rst_sel ? opp_rise : wr_hit;
    // set has priority over clear
    latch_d  = fn_out || (latch_q && !clr);
    main_d   = ctl.main_sel ? latch_d : fn_out;
    pin_d    = ctl.pin_sel  ? latch_d : fn_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opp_prev_q <= 1'b0;
      latch_q    <= 1'b0;
      main_q     <= 1'b0;
      pin_q      <= 1'b0;
    end else begin
      opp_prev_q <= opp_fn;
      latch_q    <= latch_d;
      main_q     <= main_d;
      pin_q      <= pin_d;
    end
  end

  assign aout_en = ctl.aout;

  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fn_out |=> latch_q);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fn_out && !wr_hit && !opp_fn) |=> (latch_q == $past(latch_q)));

  p_wrclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.rst_sel && wr_hit && !fn_out) |=> !latch_q);

  p_wrign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.rst_sel && !opp_fn && !fn_out) |=> (latch_q == $past(latch_q)));

  p_setwins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_out && wr_hit) |=> latch_q);

  p_main_fn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.main_sel |=> (main_q == $past(fn_out)));

  p_pin_fn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.pin_sel |=> (pin_q == $past(fn_out)));
endmodule

// File: rtl/dcc_top.sv
module dcc_top
  import dcc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [1:0]    rd_addr,
  output logic [7:0]    rd_data,
  input  logic [1:0]    cmp_raw,
  output logic [1:0]    main_out,
  output logic [1:0]    pin_out,
  output logic [1:0]    aout_en
);
  logic           rst_sync_n;
  logic [NCH-1:0] chan_en;
  logic [DW-1:0]  ctl_q, fn_q;
  logic           wr_hit;
  logic [NCH-1:0] gated;
  logic [NCH-1:0] fn_vec;

  dcc_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  dcc_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .chan_en(chan_en), .ctl_q(ctl_q), .fn_q(fn_q), .wr_hit(wr_hit)
  );

  assign gated = cmp_raw & chan_en;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_ctl_t ctl_c;
    assign ctl_c = chan_ctl_t'(ctl_q[c*CODEW +: CODEW]);

    dcc_chan u_ch (
      .clk(clk), .rst_n(rst_sync_n),
      .in_a(gated[0]), .in_b(gated[1]),
      .code(fn_q[c*CODEW +: CODEW]),
      .ctl(ctl_c),
      .wr_hit(wr_hit),
      .opp_fn(fn_vec[NCH-1-c]),
      .fn_out(fn_vec[c]),
      .main_q(main_out[c]),
      .pin_q(pin_out[c]),
      .aout_en(aout_en[c])
    );
  end

  p_dis_a_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!chan_en[0] && fn_q[3:0] == 4'h3 && ctl_q[0] == 1'b0) |=> !main_out[0]);
endmodule

// File: tb/sim_dcc_top.sv
module sim_dcc_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic [1:0] cmp_raw;
  logic [1:0] main_out, pin_out, aout_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dcc_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmp_raw(cmp_raw), .main_out(main_out), .pin_out(pin_out),
    .aout_en(aout_en)
  );

  // {code[3:0], A, B, expected}
  localparam logic [6:0] VEC [20] = '{
    7'b0000_11_0, 7'b1111_00_1, 7'b0011_10_1, 7'b0011_01_0,
    7'b0101_01_1, 7'b0101_10_0, 7'b0110_10_1, 7'b0110_11_0,
    7'b0111_00_0, 7'b0111_01_1, 7'b1000_00_1, 7'b1000_10_0,
    7'b1001_11_1, 7'b1001_01_0, 7'b1110_11_0, 7'b1110_01_1,
    7'b0001_11_1, 7'b0001_10_0, 7'b0010_10_1, 7'b0100_01_1
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [1:0] raw);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; cmp_raw = raw;
    @(posedge clk); #1;
  endtask

  task automatic cyc(input logic [1:0] raw);
    @(negedge clk);
    wr_en = 1'b0; cmp_raw = raw;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b0; rd_addr = a;
    #1 v = rd_data;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; cmp_raw = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    for (int i = 0; i < 3; i++) begin
      rd(2'(i), v); chk("R1 reg", v, 8'h00);
    end
    chk("R1 outs", {2'b00, main_out, pin_out, aout_en}, 8'h00);

    // R2 write/read, offset 3 ignored
    wr(2'd0, 8'h11, 2'b00);
    wr(2'd2, 8'h5A, 2'b00);
    wr(2'd3, 8'hFF, 2'b00);
    rd(2'd0, v); chk("R2 ofs0", v, 8'h11);
    rd(2'd2, v); chk("R2 ofs2", v, 8'h5A);
    rd(2'd1, v); chk("R2 ofs1", v, 8'h00);
    rd(2'd3, v); chk("R2 ofs3", v, 8'h00);

    // R3 function table, both channels, main path = function
    for (int k = 0; k < 20; k++) begin
      logic [3:0] c;
      c = VEC[k][6:3];
      wr(2'd2, {c, c}, 2'b00);
      cyc({VEC[k][1], VEC[k][2]});
      chk("R3 fn", {6'b0, main_out}, {6'b0, {2{VEC[k][0]}}});
    end

    // R4 enables: ch0 code 3 (A), ch1 code 5 (B)
    wr(2'd2, 8'h53, 2'b00);
    wr(2'd0, 8'h10, 2'b00);
    cyc(2'b11);
    chk("R4 A disabled", {6'b0, main_out}, 8'h02);
    wr(2'd0, 8'h01, 2'b11);
    cyc(2'b11);
    chk("R4 B disabled", {6'b0, main_out}, 8'h01);

    // R7 analog connect
    wr(2'd0, 8'h11, 2'b00);
    wr(2'd1, 8'h88, 2'b00);
    chk("R7 both", {6'b0, aout_en}, 8'h03);
    wr(2'd1, 8'h08, 2'b00);
    chk("R7 ch0", {6'b0, aout_en}, 8'h01);

    // R6 channel 1 pin from latch
    wr(2'd1, 8'h40, 2'b00);
    cyc(2'b10);
    chk("R6 pin1 set", {6'b0, pin_out[1], main_out[1]}, 8'h03);
    cyc(2'b00);
    chk("R6 pin1 latched", {7'b0, pin_out[1]}, 8'h01);
    chk("R8 main1 follows fn", {7'b0, main_out[1]}, 8'h00);

    // R5/R8/R9 channel 0 main from latch, clear on write
    wr(2'd1, 8'h01, 2'b00);
    chk("R9 cleared by write", {7'b0, main_out[0]}, 8'h00);
    @(negedge clk); wr_en = 1'b0; cmp_raw = 2'b01;
    #2 chk("R5 no change before edge", {7'b0, main_out[0]}, 8'h00);
    @(posedge clk); #1;
    chk("R5 main0 after edge", {6'b0, main_out[0], pin_out[0]}, 8'h03);
    cyc(2'b00);
    chk("R8 main0 held", {7'b0, main_out[0]}, 8'h01);
    chk("R6 pin0 fn", {7'b0, pin_out[0]}, 8'h00);
    wr(2'd2, 8'h53, 2'b00);
    chk("R9 main0 cleared", {7'b0, main_out[0]}, 8'h00);

    // R10 edge clear
    wr(2'd1, 8'h03, 2'b00);
    cyc(2'b01);
    cyc(2'b00);
    chk("R10 latched", {7'b0, main_out[0]}, 8'h01);
    wr(2'd2, 8'h53, 2'b00);
    chk("R10 write ignored", {7'b0, main_out[0]}, 8'h01);
    cyc(2'b10);
    chk("R10 edge clears", {7'b0, main_out[0]}, 8'h00);
    cyc(2'b11);
    chk("R10 re-set", {7'b0, main_out[0]}, 8'h01);
    cyc(2'b10);
    chk("R10 level no clear", {7'b0, main_out[0]}, 8'h01);

    // R11 set wins
    wr(2'd1, 8'h01, 2'b00);
    chk("R10 old select ignores write", {7'b0, main_out[0]}, 8'h01);
    wr(2'd2, 8'h53, 2'b00);
    chk("R9 clear", {7'b0, main_out[0]}, 8'h00);
    wr(2'd2, 8'h53, 2'b01);
    chk("R11 set wins", {7'b0, main_out[0]}, 8'h01);
    cyc(2'b00);
    chk("R11 stays set", {7'b0, main_out[0]}, 8'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule